// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This block is the control unit of a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and writeback. Each cycle it compares the source registers of the instruction in decode with the destination fields of the instructions in the execute latch and the memory latch. From that comparison it decides whether decode must wait. When decode waits, the block holds the fetch and decode latches and puts a bubble into execute. When forwarding is enabled, it also chooses where each execute-stage operand comes from. A taken branch or a jump-and-link makes it discard the younger instructions that were fetched behind it.

A static mode input picks one of two policies:
- **Full interlock:** the consumer waits until its producer has left the memory stage. The register file writes before it reads within a cycle, so a producer that has reached writeback is already visible.
- **Forwarding:** results are bypassed from the execute-memory latch and the memory-writeback latch. Only a load immediately followed by a consumer costs a cycle.

The block also keeps saturating counters for cycles, stall cycles, killed instructions and retired instructions. Software derives IPC from the retired count and the cycle count.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: With `fwd_en_i`=0, `stall_o` is high whenever a valid decode source matches the nonzero destination of a write-enabled instruction in the execute latch or the memory latch.
- R2: With `fwd_en_i`=1, a match against a non-load producer in the execute latch does not stall, and in the next cycle that source's select reads 1 (take the execute-memory latch).
- R3: With `fwd_en_i`=1, a match against the memory latch does not stall, and in the next cycle that source's select reads 2 (take the memory-writeback latch).
- R4: With `fwd_en_i`=1, a match against a load in the execute latch stalls. Once the load has moved to the memory latch there is no stall and the select reads 2, so a load-use pair costs exactly one stall cycle.
- R5: When both latches match the same source, the select reads 1; the younger result wins.
- R6: A source equal to x0, a producer with write-enable low, and an invalid decode slot never cause a stall or a forward.
- R7: During a stall, `hold_if_o`, `hold_id_o` and `bubble_ex_o` are high, and both selects read 0 in the next cycle. With `fwd_en_i`=0 the selects always read 0.
- R8: A taken branch raises `kill_if_o` and `kill_id_o`, two instructions in all. A jump raises only `kill_if_o`, one instruction. The behaviour is the same in both modes, and a taken branch also raises `bubble_ex_o`.
- R9: A taken branch suppresses any stall requested in the same cycle.
- R10: The counters change after each clock edge:
  - the cycle counter adds 1 on every edge;
  - the stall counter adds 1 for each cycle in which `stall_o` is high;
  - the kill counter adds 2 for a taken branch (also when a jump arrives in the same cycle) and 1 for a jump alone;
  - the retire counter adds 1 for each cycle in which `wb_valid_i` is high.
- R11: Each counter saturates at all ones, including when an increment of 2 would overflow.
- R12: `cnt_clr_i` zeroes all counters at the next clock edge and takes priority over any increment. Asynchronous reset zeroes all counters and selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwd_en_i | input | 1 | 1 = forwarding mode, 0 = full interlock |
| id_valid_i | input | 1 | Decode slot holds a real instruction |
| id_rs1_i | input | REG_AW | First source register of the instruction in decode (0 if unused) |
| id_rs2_i | input | REG_AW | Second source register of the instruction in decode (0 if unused) |
| ex_rd_i | input | REG_AW | Destination register in the execute latch |
| ex_we_i | input | 1 | Register write-enable in the execute latch |
| ex_load_i | input | 1 | Execute latch holds a load |
| mem_rd_i | input | REG_AW | Destination register in the memory latch |
| mem_we_i | input | 1 | Register write-enable in the memory latch |
| wb_valid_i | input | 1 | A real instruction completes writeback this cycle |
| br_taken_i | input | 1 | Conditional branch in execute resolved taken |
| jump_i | input | 1 | Jump-and-link in decode |
| cnt_clr_i | input | 1 | Synchronous clear of all counters |
| stall_o | output | 1 | Decode stall |
| hold_if_o | output | 1 | Hold the fetch latch |
| hold_id_o | output | 1 | Hold the decode latch |
| bubble_ex_o | output | 1 | Load a bubble with cleared write-enables into execute |
| kill_if_o | output | 1 | Discard the instruction being fetched |
| kill_id_o | output | 1 | Discard the instruction in decode |
| fwd_a_o | output | 2 | Select for operand 1 in execute: 0 register file, 1 execute-memory latch, 2 memory-writeback latch |
| fwd_b_o | output | 2 | Select for operand 2 in execute, same encoding |
| cycle_cnt_o | output | CNT_W | Cycle count |
| stall_cnt_o | output | CNT_W | Stall cycle count |
| kill_cnt_o | output | CNT_W | Killed instruction count |
| retire_cnt_o | output | CNT_W | Retired instruction count |

## Verification
The bench builds the block with `REG_AW`=5 and `CNT_W`=6. With that counter width, the saturation limit of 63 is reached within a few dozen cycles. This puts the overflow behaviour of the stall, cycle and kill counters within reach, including the step of 2 that crosses the limit. The register width covers the full set of 32 registers, so x0 and the largest register numbers both appear in the comparisons.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'd0,
    FWD_EXMEM = 2'd1,
    FWD_MEMWB = 2'd2
  } fwd_sel_e;

  localparam int unsigned NUM_SRC   = 2;
  localparam int unsigned NUM_CNT   = 4;
  localparam int unsigned INC_W     = 2;
  localparam int unsigned CNT_CYC   = 0;
  localparam int unsigned CNT_STALL = 1;
  localparam int unsigned CNT_KILL  = 2;
  localparam int unsigned CNT_RET   = 3;
endpackage

// File: rtl/phc_hazard.sv
module phc_hazard
  import pipe_hazard_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic                           fwd_en_i,
  input  logic                           id_valid_i,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] id_rs_i,
  input  logic [REG_AW-1:0]              ex_rd_i,
  input  logic                           ex_we_i,
  input  logic                           ex_load_i,
  input  logic [REG_AW-1:0]              mem_rd_i,
  input  logic                           mem_we_i,
  input  logic                           flush_i,
  output logic [NUM_SRC-1:0]             ex_hit_o,
  output logic [NUM_SRC-1:0]             mem_hit_o,
  output logic                           stall_o
);
  logic [NUM_SRC-1:0] src_stall;
  logic               ex_live, mem_live;

  // x0 is never a real producer
  assign ex_live  = ex_we_i  && (ex_rd_i  != '0);
  assign mem_live = mem_we_i && (mem_rd_i != '0);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign ex_hit_o[s]  = id_valid_i && ex_live  && (id_rs_i[s] == ex_rd_i);
    assign mem_hit_o[s] = id_valid_i && mem_live && (id_rs_i[s] == mem_rd_i);
    // forwarding: only a load still in execute blocks; interlock: any in-flight producer
    assign src_stall[s] = fwd_en_i ? (ex_hit_o[s] && ex_load_i)
                                   : (ex_hit_o[s] || mem_hit_o[s]);
  end

  // flush wins: a doomed decode slot must not stall
  assign stall_o = (|src_stall) && !flush_i;
endmodule

// File: rtl/phc_fwd.sv
module phc_fwd
  import pipe_hazard_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fwd_en_i,
  input  logic                      bubble_i,
  input  logic [NUM_SRC-1:0]        ex_hit_i,
  input  logic [NUM_SRC-1:0]        mem_hit_i,
  output logic [NUM_SRC-1:0][1:0]   sel_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sel
    fwd_sel_e sel_d;

    always_comb begin
      if (bubble_i || !fwd_en_i) sel_d = FWD_RF;
      else if (ex_hit_i[s])      sel_d = FWD_EXMEM;  // younger result first
      else if (mem_hit_i[s])     sel_d = FWD_MEMWB;
      else                       sel_d = FWD_RF;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_o[s] <= FWD_RF;
      else         sel_o[s] <= sel_d;
    end

    // R3
    memwb_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_o[s] == FWD_MEMWB) |-> $past(mem_hit_i[s]));

    // R7
    no_fwd_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fwd_en_i |=> (sel_o[s] == FWD_RF));
  end
endmodule

// File: rtl/phc_flush.sv
module phc_flush
  import pipe_hazard_pkg::*;
(
  input  logic             br_taken_i,
  input  logic             jump_i,
  output logic             kill_if_o,
  output logic             kill_id_o,
  output logic [INC_W-1:0] kill_num_o
);
  // branch resolves in execute: two younger slots; jump in decode: one
  assign kill_if_o  = br_taken_i || jump_i;
  assign kill_id_o  = br_taken_i;
  assign kill_num_o = br_taken_i ? INC_W'(2) : (jump_i ? INC_W'(1) : INC_W'(0));
endmodule

// File: rtl/phc_perf.sv
module phc_perf
  import pipe_hazard_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic [NUM_CNT-1:0][INC_W-1:0]  inc_i,
  output logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    logic [CNT_W:0] sum;

    assign sum = {1'b0, cnt_o[c]} + (CNT_W+1)'(inc_i[c]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_o[c] <= '0;
      else if (clr_i)  cnt_o[c] <= '0;
      else if (sum[CNT_W]) cnt_o[c] <= CNT_MAX;
      else             cnt_o[c] <= sum[CNT_W-1:0];
    end

    // R11
    sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_o[c] == CNT_MAX && !clr_i) |=> (cnt_o[c] == CNT_MAX));

    // R10
    monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (cnt_o[c] >= $past(cnt_o[c])));

    // R12
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_o[c] == '0));
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import pipe_hazard_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwd_en_i,
  input  logic              id_valid_i,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic              wb_valid_i,
  input  logic              br_taken_i,
  input  logic              jump_i,
  input  logic              cnt_clr_i,
  output logic              stall_o,
  output logic              hold_if_o,
  output logic              hold_id_o,
  output logic              bubble_ex_o,
  output logic              kill_if_o,
  output logic              kill_id_o,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic [CNT_W-1:0]  cycle_cnt_o,
  output logic [CNT_W-1:0]  stall_cnt_o,
  output logic [CNT_W-1:0]  kill_cnt_o,
  output logic [CNT_W-1:0]  retire_cnt_o
);
  logic [NUM_SRC-1:0][REG_AW-1:0] id_rs;
  logic [NUM_SRC-1:0]             ex_hit, mem_hit;
  logic [NUM_SRC-1:0][1:0]        sel;
  logic [INC_W-1:0]               kill_num;
  logic [NUM_CNT-1:0][INC_W-1:0]  inc;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;

  assign id_rs[0] = id_rs1_i;
  assign id_rs[1] = id_rs2_i;

  phc_hazard #(.REG_AW(REG_AW)) u_hazard (
    .fwd_en_i   (fwd_en_i),
    .id_valid_i (id_valid_i),
    .id_rs_i    (id_rs),
    .ex_rd_i    (ex_rd_i),
    .ex_we_i    (ex_we_i),
    .ex_load_i  (ex_load_i),
    .mem_rd_i   (mem_rd_i),
    .mem_we_i   (mem_we_i),
    .flush_i    (br_taken_i),
    .ex_hit_o   (ex_hit),
    .mem_hit_o  (mem_hit),
    .stall_o    (stall_o)
  );

  phc_flush u_flush (
    .br_taken_i (br_taken_i),
    .jump_i     (jump_i),
    .kill_if_o  (kill_if_o),
    .kill_id_o  (kill_id_o),
    .kill_num_o (kill_num)
  );

  assign hold_if_o   = stall_o;
  assign hold_id_o   = stall_o;
  assign bubble_ex_o = stall_o || kill_id_o;

  phc_fwd u_fwd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fwd_en_i  (fwd_en_i),
    .bubble_i  (bubble_ex_o),
    .ex_hit_i  (ex_hit),
    .mem_hit_i (mem_hit),
    .sel_o     (sel)
  );

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  assign inc[CNT_CYC]   = INC_W'(1);
  assign inc[CNT_STALL] = INC_W'(stall_o);
  assign inc[CNT_KILL]  = kill_num;
  assign inc[CNT_RET]   = INC_W'(wb_valid_i);

  phc_perf #(.CNT_W(CNT_W)) u_perf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr_i),
    .inc_i  (inc),
    .cnt_o  (cnt)
  );

  assign cycle_cnt_o  = cnt[CNT_CYC];
  assign stall_cnt_o  = cnt[CNT_STALL];
  assign kill_cnt_o   = cnt[CNT_KILL];
  assign retire_cnt_o = cnt[CNT_RET];

  // R9
  flush_over_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !kill_id_o);

  // R8
  kill_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_id_o |-> kill_if_o);

  // R6
  x0_no_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs1_i == '0) |=> (fwd_a_o == 2'd0));

  // R7
  stall_clears_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (fwd_a_o == 2'd0 && fwd_b_o == 2'd0));
endmodule

// File: tb/pipe_hazard_ctrl_tb.sv
module pipe_hazard_ctrl_tb;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned CNT_W  = 6;
  localparam int unsigned SAT    = (1 << CNT_W) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fwd_en_i, id_valid_i, ex_we_i, ex_load_i, mem_we_i;
  logic wb_valid_i, br_taken_i, jump_i, cnt_clr_i;
  logic [REG_AW-1:0] id_rs1_i, id_rs2_i, ex_rd_i, mem_rd_i;
  logic stall_o, hold_if_o, hold_id_o, bubble_ex_o, kill_if_o, kill_id_o;
  logic [1:0] fwd_a_o, fwd_b_o;
  logic [CNT_W-1:0] cycle_cnt_o, stall_cnt_o, kill_cnt_o, retire_cnt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pipe_hazard_ctrl #(.REG_AW(REG_AW), .CNT_W(CNT_W)) u_dut (.*);

  typedef struct packed {
    logic [3:0] req;
    logic       fwd, vld;
    logic [4:0] rs1, rs2, exd;
    logic       exw, exl;
    logic [4:0] md;
    logic       mw, br, jp;
    logic       st, kif, kid;
    logic [1:0] fa, fb;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    // R1 no match, R1 ex match, R1 mem match
    '{4'd1, 1'b0,1'b1, 5'd1,5'd2, 5'd3,1'b1,1'b0, 5'd4,1'b1, 1'b0,1'b0, 1'b0,1'b0,1'b0, 2'd0,2'd0},
    '{4'd1, 1'b0,1'b1, 5'd1,5'd2, 5'd1,1'b1,1'b0, 5'd4,1'b1, 1'b0,1'b0, 1'b1,1'b0,1'b0, 2'd0,2'd0},
    '{4'd1, 1'b0,1'b1, 5'd1,5'd2, 5'd3,1'b1,1'b0, 5'd2,1'b1, 1'b0,1'b0, 1'b1,1'b0,1'b0, 2'd0,2'd0},
    // R2 ex forward, R3 mem forward, R5 both latches
    '{4'd2, 1'b1,1'b1, 5'd1,5'd2, 5'd1,1'b1,1'b0, 5'd4,1'b1, 1'b0,1'b0, 1'b0,1'b0,1'b0, 2'd1,2'd0},
    '{4'd3, 1'b1,1'b1, 5'd1,5'd2, 5'd3,1'b1,1'b0, 5'd2,1'b1, 1'b0,1'b0, 1'b0,1'b0,1'b0, 2'd0,2'd2},
    '{4'd5, 1'b1,1'b1, 5'd1,5'd2, 5'd1,1'b1,1'b0, 5'd1,1'b1, 1'b0,1'b0, 1'b0,1'b0,1'b0, 2'd1,2'd0},
    // R4 load-use: stall, then forward from memory latch
    '{4'd4, 1'b1,1'b1, 5'd1,5'd2, 5'd2,1'b1,1'b1, 5'd4,1'b1, 1'b0,1'b0, 1'b1,1'b0,1'b0, 2'd0,2'd0},
    '{4'd4, 1'b1,1'b1, 5'd1,5'd2, 5'd3,1'b0,1'b0, 5'd1,1'b1, 1'b0,1'b0, 1'b0,1'b0,1'b0, 2'd2,2'd0},
    // R6 x0, write-enable low, invalid slot
    '{4'd6, 1'b0,1'b1, 5'd0,5'd2, 5'd0,1'b1,1'b0, 5'd0,1'b1, 1'b0,1'b0, 1'b0,1'b0,1'b0, 2'd0,2'd0},
    '{4'd6, 1'b1,1'b1, 5'd0,5'd0, 5'd0,1'b1,1'b0, 5'd0,1'b1, 1'b0,1'b0, 1'b0,1'b0,1'b0, 2'd0,2'd0},
    '{4'd6, 1'b0,1'b1, 5'd1,5'd2, 5'd1,1'b0,1'b0, 5'd2,1'b0, 1'b0,1'b0, 1'b0,1'b0,1'b0, 2'd0,2'd0},
    '{4'd6, 1'b1,1'b1, 5'd1,5'd2, 5'd1,1'b0,1'b0, 5'd2,1'b0, 1'b0,1'b0, 1'b0,1'b0,1'b0, 2'd0,2'd0},
    '{4'd6, 1'b1,1'b0, 5'd1,5'd2, 5'd1,1'b1,1'b1, 5'd2,1'b1, 1'b0,1'b0, 1'b0,1'b0,1'b0, 2'd0,2'd0},
    // R9 branch overrides interlock stall
    '{4'd9, 1'b0,1'b1, 5'd1,5'd2, 5'd1,1'b1,1'b0, 5'd4,1'b1, 1'b1,1'b0, 1'b0,1'b1,1'b1, 2'd0,2'd0},
    // R8 jump, branch in forwarding mode
    '{4'd8, 1'b0,1'b1, 5'd3,5'd4, 5'd5,1'b1,1'b0, 5'd6,1'b1, 1'b0,1'b1, 1'b0,1'b1,1'b0, 2'd0,2'd0},
    '{4'd8, 1'b1,1'b1, 5'd1,5'd2, 5'd1,1'b1,1'b0, 5'd4,1'b1, 1'b1,1'b0, 1'b0,1'b1,1'b1, 2'd0,2'd0},
    // R5 both sources on one producer, top register
    '{4'd5, 1'b1,1'b1, 5'd31,5'd31, 5'd31,1'b1,1'b0, 5'd31,1'b1, 1'b0,1'b0, 1'b0,1'b0,1'b0, 2'd1,2'd1},
    // R9 branch overrides load-use stall
    '{4'd9, 1'b1,1'b1, 5'd1,5'd2, 5'd1,1'b1,1'b1, 5'd4,1'b1, 1'b1,1'b0, 1'b0,1'b1,1'b1, 2'd0,2'd0},
    // R8 branch and jump together
    '{4'd8, 1'b0,1'b1, 5'd3,5'd4, 5'd5,1'b1,1'b0, 5'd6,1'b1, 1'b1,1'b1, 1'b0,1'b1,1'b1, 2'd0,2'd0},
    // R7 stall discards a pending memory forward
    '{4'd7, 1'b1,1'b1, 5'd1,5'd2, 5'd1,1'b1,1'b1, 5'd2,1'b1, 1'b0,1'b0, 1'b1,1'b0,1'b0, 2'd0,2'd0}
  };

  task automatic chk(input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    id_valid_i = 1'b0; id_rs1_i = '0; id_rs2_i = '0;
    ex_rd_i = '0; ex_we_i = 1'b0; ex_load_i = 1'b0;
    mem_rd_i = '0; mem_we_i = 1'b0;
    wb_valid_i = 1'b0; br_taken_i = 1'b0; jump_i = 1'b0; cnt_clr_i = 1'b0;
  endtask

  task automatic interlock_stall();
    fwd_en_i = 1'b0; id_valid_i = 1'b1; id_rs1_i = 5'd1;
    ex_rd_i = 5'd1; ex_we_i = 1'b1;
  endtask

  task automatic clear_cnt();
    @(negedge clk_i); idle(); cnt_clr_i = 1'b1;
    @(negedge clk_i); cnt_clr_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL R0 watchdog expired");
      summary();
    end
  end

  initial begin
    fwd_en_i = 1'b0;
    idle();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R12 reset state
    chk(12, "reset stall/kill", {26'd0, stall_o, bubble_ex_o, kill_if_o, kill_id_o, hold_if_o, hold_id_o}, 32'd0);
    chk(12, "reset selects", {28'd0, fwd_a_o, fwd_b_o}, 32'd0);
    chk(12, "reset counters", {8'd0, cycle_cnt_o, stall_cnt_o, kill_cnt_o, retire_cnt_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      fwd_en_i = VECS[i].fwd; id_valid_i = VECS[i].vld;
      id_rs1_i = VECS[i].rs1; id_rs2_i = VECS[i].rs2;
      ex_rd_i = VECS[i].exd; ex_we_i = VECS[i].exw; ex_load_i = VECS[i].exl;
      mem_rd_i = VECS[i].md; mem_we_i = VECS[i].mw;
      br_taken_i = VECS[i].br; jump_i = VECS[i].jp;
      #1;
      chk(VECS[i].req, $sformatf("vec %0d stall/hold/bubble/kill", i),
          {26'd0, stall_o, hold_if_o, hold_id_o, bubble_ex_o, kill_if_o, kill_id_o},
          {26'd0, VECS[i].st, VECS[i].st, VECS[i].st, VECS[i].st | VECS[i].br,
           VECS[i].kif, VECS[i].kid});
      @(posedge clk_i); #1;
      chk(VECS[i].req, $sformatf("vec %0d selects", i),
          {28'd0, fwd_a_o, fwd_b_o}, {28'd0, VECS[i].fa, VECS[i].fb});
    end

    // R10 counting sequence
    clear_cnt();
    interlock_stall(); wb_valid_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); idle(); br_taken_i = 1'b1;
    @(negedge clk_i); idle(); jump_i = 1'b1; wb_valid_i = 1'b1;
    @(negedge clk_i); idle(); br_taken_i = 1'b1; jump_i = 1'b1;
    @(posedge clk_i); #1;
    chk(10, "cycle count", 32'(cycle_cnt_o), 32'd5);
    chk(10, "stall count", 32'(stall_cnt_o), 32'd2);
    chk(10, "kill count", 32'(kill_cnt_o), 32'd5);
    chk(10, "retire count", 32'(retire_cnt_o), 32'd3);

    // R12 clear beats a concurrent stall increment
    @(negedge clk_i); idle(); interlock_stall(); cnt_clr_i = 1'b1;
    @(posedge clk_i); #1;
    chk(12, "clear stall count", 32'(stall_cnt_o), 32'd0);
    chk(12, "clear cycle count", 32'(cycle_cnt_o), 32'd0);

    // R11 stall and cycle counters saturate
    @(negedge clk_i); cnt_clr_i = 1'b0;
    repeat (70) @(negedge clk_i);
    chk(11, "stall saturation", 32'(stall_cnt_o), SAT);
    chk(11, "cycle saturation", 32'(cycle_cnt_o), SAT);

    // R11 kill counter saturates across a step of 2
    clear_cnt();
    br_taken_i = 1'b1; wb_valid_i = 1'b1;
    repeat (40) @(negedge clk_i);
    chk(11, "kill saturation", 32'(kill_cnt_o), SAT);
    chk(10, "retire under branches", 32'(retire_cnt_o), 32'd40);
    chk(10, "cycle under branches", 32'(cycle_cnt_o), 32'd40);
    chk(9, "no stall counted under branch", 32'(stall_cnt_o), 32'd0);

    done = 1'b1;
    summary();
  end
endmodule